// File: doc/BRIEF.md
# Sequenced-Service Watchdog Timer

This block is a watchdog timer with a 16-bit register port. It counts down in half-second ticks derived from a slow clock. Software can restart the countdown only by writing two fixed key words, in order, to a service location. If the countdown runs out while the watchdog is armed, the block pulses a reset request for one cycle. It also records in a status register that the last reset came from a timeout. A control bit gives software a way to request a reset on its own, and that event is recorded too.

Software starts the watchdog by writing a timeout field and the enable bit. Once the enable bit is set it stays set until the block is reset. The low-power hold bit can be written only once. A separate power-on counter drives an interrupt line low for one cycle when it runs out, unless software disables it early. The register map is: control at 0x0, service at 0x2, status at 0x4, power-down control at 0x8. Reads return data combinationally for the address on the bus.

Top module: `svc_watchdog`

## Requirements
- R1: After reset, control reads 0x0018, status reads 0x0000 and power-down control reads 0x0001. The reset request and software request outputs are low, and the interrupt line is high. Control layout: [15:8] timeout field, bit 4 software-request bit (always reads 1), bit 3 reset-enable, bit 2 enable, bit 0 low-power hold.
- R2: A control write that sets bit 2 while the watchdog is idle loads timeout field N. The reset request is then high for exactly one cycle, starting (N+1)*TICK_CYCLES cycles after that write's clock edge.
- R3: The service location (0x2) reloads the countdown, and restarts the tick prescaler, only when 0xAAAA is written directly after 0x5555. Orders such as 0xAAAA alone, 0x5555 then another word then 0xAAAA, or 0xAAAA then 0x5555 leave the countdown running.
- R4: Writing 0 to the enable bit while the watchdog runs has no effect. The bit still reads 1 and expiry still happens on time.
- R5: The low-power hold bit takes its value from the first control write after reset or expiry. Later writes leave it unchanged.
- R6: While the hold bit is 1 and the low_power input is high, the countdown and prescaler freeze, so expiry moves later by exactly the number of frozen cycles. When the hold bit is 0, low_power has no effect.
- R7: A new timeout field written while running does not change the current countdown. It is used from the next reload on.
- R8: A reset-generating expiry sets status bit 1, clears status bit 0, returns control to 0x0018 and discards a pending first key. Writes to the status register are ignored.
- R9: With reset-enable (bit 3) clear, expiry produces no reset request and the countdown reloads from the field, period after period.
- R10: A control write with bit 4 equal to 0 pulses the software request output for one cycle, starting at the next cycle. It also sets status bit 0 and clears bit 1, whether or not the watchdog is enabled.
- R11: With the power-down counter enabled, the interrupt line goes low for one cycle, starting PDN_CYCLES clock edges after reset is released, and only once.
- R12: Writing the power-down control with bit 0 equal to 0 disables the counter permanently until reset. A later write of 1 does not re-enable it, and no interrupt pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| low_power | input | 1 | Low-power mode indication |
| wdog_rst_o | output | 1 | One-cycle reset request on expiry |
| sw_rst_o | output | 1 | One-cycle software reset request |
| pdn_int_n | output | 1 | Power-down interrupt, active low, one cycle |

## Verification
The countdown is driven with random timeout values and random service delays, combined with four service patterns. One is the correct key pair, one has a doubled first key, one has an intervening foreign word, and one has the keys reversed. Checking the exact expiry cycle shows whether a pattern reloaded the count, and whether the reload used the current field and restarted the prescaler. Directed cases move the expiry cycle by low-power freeze windows, with the hold bit set and with it clear. They also rewrite the field mid-count and let the silent wrap mode run through several periods, and the expiry cycle again tells these cases apart.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
    localparam int REG_W = 16;
    localparam int TMO_W = 8;

    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_SVC  = 4'h2;
    localparam logic [3:0] OFS_STAT = 4'h4;
    localparam logic [3:0] OFS_MISC = 4'h8;

    localparam logic [REG_W-1:0] KEY_FIRST  = 16'h5555;
    localparam logic [REG_W-1:0] KEY_SECOND = 16'hAAAA;

    localparam int B_HOLD  = 0;
    localparam int B_EN    = 2;
    localparam int B_RSTEN = 3;
    localparam int B_SWREQ = 4;

    typedef struct packed {
        logic [TMO_W-1:0] tmo;
        logic             rst_en;
        logic             en;
        logic             hold;
        logic             hold_lock;
    } ctrl_t;

    localparam ctrl_t CTRL_INIT = '{tmo: '0, rst_en: 1'b1, en: 1'b0,
                                    hold: 1'b0, hold_lock: 1'b0};
endpackage

// File: rtl/wdt_key_seq.sv
`timescale 1ns/1ps
module wdt_key_seq
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             svc_wr_i,
    input  logic [REG_W-1:0] data_i,
    input  logic             flush_i,
    output logic             reload_o
);
    logic armed_d, armed_q;

    always_comb begin
        armed_d  = armed_q;
        reload_o = 1'b0;
        if (svc_wr_i) begin
            reload_o = armed_q && (data_i == KEY_SECOND);
            armed_d  = (data_i == KEY_FIRST);
        end
        if (flush_i) begin
            armed_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end

    // R3: a completed key pair always consumes the armed state
    p_reload_disarm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reload_o |=> !armed_q);
endmodule

// File: rtl/wdt_countdown.sv
`timescale 1ns/1ps
module wdt_countdown #(
    parameter int TICK_CYCLES = 16384,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             hold_i,
    input  logic             load_i,
    input  logic             wrap_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expire_o
);
    localparam int PW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] PRESC_LAST = PW'(TICK_CYCLES - 1);

    typedef struct packed {
        logic [PW-1:0]    presc;
        logic [CNT_W-1:0] cnt;
    } cd_t;

    cd_t cd_d, cd_q;

    always_comb begin
        cd_d     = cd_q;
        expire_o = 1'b0;
        if (load_i) begin
            cd_d.presc = '0;
            cd_d.cnt   = load_val_i;
        end else if (run_i && !hold_i) begin
            if (cd_q.presc == PRESC_LAST) begin
                cd_d.presc = '0;
                if (cd_q.cnt == '0) begin
                    expire_o = 1'b1;
                    if (wrap_i) cd_d.cnt = load_val_i;
                end else begin
                    cd_d.cnt = cd_q.cnt - 1'b1;
                end
            end else begin
                cd_d.presc = cd_q.presc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cd_q <= '0;
        else        cd_q <= cd_d;
    end

    // R6: a held countdown keeps both prescaler and count
    p_hold_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && hold_i && !load_i) |=> $stable(cd_q));
    // R4: an idle countdown never moves on its own
    p_idle_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(cd_q.cnt));
endmodule

// File: rtl/wdt_pdn_timer.sv
`timescale 1ns/1ps
module wdt_pdn_timer #(
    parameter int PDN_CYCLES = 524288
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic pdn_int_n
);
    localparam int CW = (PDN_CYCLES > 2) ? $clog2(PDN_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(PDN_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
        logic          pulse;
    } pdn_t;

    pdn_t p_d, p_q;

    always_comb begin
        p_d       = p_q;
        p_d.pulse = 1'b0;
        if (en_i && !p_q.done) begin
            if (p_q.cnt == CNT_LAST) begin
                p_d.pulse = 1'b1;
                p_d.done  = 1'b1;
            end else begin
                p_d.cnt = p_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign pdn_int_n = !p_q.pulse;

    // R11: the counter fires once and then stays finished
    p_pdn_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.done |=> p_q.done);
    p_pdn_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_int_n |=> pdn_int_n);
endmodule

// File: rtl/svc_watchdog.sv
`timescale 1ns/1ps
module svc_watchdog
    import wdt_pkg::*;
#(
    parameter int TICK_CYCLES = 16384,
    parameter int PDN_CYCLES  = 524288
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             low_power,
    output logic             wdog_rst_o,
    output logic             sw_rst_o,
    output logic             pdn_int_n
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  st_tout;
        logic  st_sw;
        logic  pdn_en;
        logic  wdog_rst;
        logic  sw_rst;
    } top_t;

    top_t st_d, st_q;

    logic             ctrl_wr, svc_wr, misc_wr;
    logic             start_load, svc_reload, cd_expire, fatal_expire;
    logic [TMO_W-1:0] load_val;

    assign ctrl_wr      = wr_en && (addr == OFS_CTRL);
    assign svc_wr       = wr_en && (addr == OFS_SVC);
    assign misc_wr      = wr_en && (addr == OFS_MISC);
    assign start_load   = ctrl_wr && wdata[B_EN] && !st_q.ctrl.en;
    assign load_val     = start_load ? wdata[REG_W-1:REG_W-TMO_W] : st_q.ctrl.tmo;
    assign fatal_expire = cd_expire && st_q.ctrl.rst_en;

    wdt_key_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc_wr_i (svc_wr),
        .data_i   (wdata),
        .flush_i  (fatal_expire),
        .reload_o (svc_reload)
    );

    wdt_countdown #(
        .TICK_CYCLES (TICK_CYCLES),
        .CNT_W       (TMO_W)
    ) u_cd (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (st_q.ctrl.en),
        .hold_i     (low_power && st_q.ctrl.hold),
        .load_i     (start_load || svc_reload),
        .wrap_i     (!st_q.ctrl.rst_en),
        .load_val_i (load_val),
        .expire_o   (cd_expire)
    );

    wdt_pdn_timer #(
        .PDN_CYCLES (PDN_CYCLES)
    ) u_pdn (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (st_q.pdn_en),
        .pdn_int_n (pdn_int_n)
    );

    always_comb begin
        st_d          = st_q;
        st_d.wdog_rst = 1'b0;
        st_d.sw_rst   = 1'b0;
        if (ctrl_wr) begin
            st_d.ctrl.tmo    = wdata[REG_W-1:REG_W-TMO_W];
            st_d.ctrl.rst_en = wdata[B_RSTEN];
            if (wdata[B_EN]) st_d.ctrl.en = 1'b1;
            if (!st_q.ctrl.hold_lock) begin
                st_d.ctrl.hold      = wdata[B_HOLD];
                st_d.ctrl.hold_lock = 1'b1;
            end
            if (!wdata[B_SWREQ]) begin
                st_d.sw_rst  = 1'b1;
                st_d.st_sw   = 1'b1;
                st_d.st_tout = 1'b0;
            end
        end
        if (misc_wr && !wdata[0]) begin
            st_d.pdn_en = 1'b0;
        end
        if (fatal_expire) begin
            st_d.ctrl     = CTRL_INIT;
            st_d.wdog_rst = 1'b1;
            st_d.st_tout  = 1'b1;
            st_d.st_sw    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.ctrl   <= CTRL_INIT;
            st_q.pdn_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CTRL: rdata = {st_q.ctrl.tmo, 3'b000, 1'b1, st_q.ctrl.rst_en,
                               st_q.ctrl.en, 1'b0, st_q.ctrl.hold};
            OFS_STAT: rdata = {14'd0, st_q.st_tout, st_q.st_sw};
            OFS_MISC: rdata = {15'd0, st_q.pdn_en};
            default:  rdata = '0;
        endcase
    end

    assign wdog_rst_o = st_q.wdog_rst;
    assign sw_rst_o   = st_q.sw_rst;

    // R2: reset request lasts one cycle
    p_rst_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst_o |=> !wdog_rst_o);
    // R4: enable survives everything except a reset-generating expiry
    p_en_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.en && !cd_expire) |=> st_q.ctrl.en);
    // R5: locked hold bit does not move
    p_hold_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.hold_lock && !cd_expire) |=> $stable(st_q.ctrl.hold));
    // R8: timeout status only rises together with a reset request
    p_tout_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.st_tout) |-> wdog_rst_o);
    // R10: software status only rises together with a software request
    p_sw_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.st_sw) |-> sw_rst_o);
endmodule

// File: tb/svc_watchdog_tb.sv
`timescale 1ns/1ps
module svc_watchdog_tb_top;
    localparam int T   = 8;
    localparam int PDN = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        low_power = 1'b0;
    logic        wdog_rst_o, sw_rst_o, pdn_int_n;

    int vec = 0;
    int bad = 0;
    int ecnt = 0;
    int pdn_hits = 0;
    int pdn_at = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) ecnt <= ecnt + 1;
    always @(negedge clk) begin
        if (rst_n && !pdn_int_n) begin
            pdn_hits = pdn_hits + 1;
            pdn_at   = ecnt;
        end
    end

    svc_watchdog #(.TICK_CYCLES(T), .PDN_CYCLES(PDN)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .low_power(low_power), .wdog_rst_o(wdog_rst_o),
        .sw_rst_o(sw_rst_o), .pdn_int_n(pdn_int_n)
    );

    function automatic int expiry_edge(int base, int n);
        return base + (n + 1) * T;
    endfunction

    task automatic chk(string req, int act, int exp);
        vec = vec + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=0x%0h expected=0x%0h at edge %0d", req, act, exp, ecnt);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, output int edge_i);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        edge_i = ecnt;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic expect_rst(int x, string req);
        while (ecnt < x - 1) @(negedge clk);
        chk(req, int'(wdog_rst_o), 0);
        @(negedge clk);
        chk(req, int'(wdog_rst_o), 1);
        @(negedge clk);
        chk(req, int'(wdog_rst_o), 0);
    endtask

    task automatic lp_window(int len);
        @(negedge clk);
        low_power = 1'b1;
        repeat (len) @(negedge clk);
        low_power = 1'b0;
    endtask

    task automatic do_reset(output int rel);
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        rel = ecnt;
        pdn_hits = 0;
    endtask

    initial begin
        #(5 * 150000);
        bad = bad + 1;
        $display("FAIL watchdog expired actual=hung expected=finished");
        if (!finished) $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        int rel, ew, er, e2;
        logic [15:0] v;
        void'($urandom(32'd1234));
        do_reset(rel);

        // R1 reset values
        rd(4'h0, v); chk("R1 ctrl", v, 16'h0018);
        rd(4'h4, v); chk("R1 status", v, 16'h0000);
        rd(4'h8, v); chk("R1 misc", v, 16'h0001);
        chk("R1 outputs", {wdog_rst_o, sw_rst_o, pdn_int_n}, 3'b001);

        // R10 software request while idle
        wr(4'h0, 16'h0008, ew);
        chk("R10 pulse", int'(sw_rst_o), 1);
        @(negedge clk); chk("R10 pulse end", int'(sw_rst_o), 0);
        rd(4'h4, v); chk("R10 status", v, 16'h0001);
        rd(4'h0, v); chk("R10 bit4 reads 1", v, 16'h0018);

        // R2 basic expiry, R8 status and re-init
        wr(4'h0, {8'd3, 8'h1C}, ew);
        expect_rst(expiry_edge(ew, 3), "R2 expiry");
        rd(4'h4, v); chk("R8 status", v, 16'h0002);
        rd(4'h0, v); chk("R8 ctrl reinit", v, 16'h0018);
        wr(4'h4, 16'hFFFF, e2);
        rd(4'h4, v); chk("R8 status write ignored", v, 16'h0002);

        // R10 while enabled, expiry undisturbed
        wr(4'h0, {8'd5, 8'h1C}, ew);
        wr(4'h0, {8'd5, 8'h0C}, e2);
        chk("R10 pulse enabled", int'(sw_rst_o), 1);
        rd(4'h4, v); chk("R10 status enabled", v, 16'h0001);
        expect_rst(expiry_edge(ew, 5), "R10 expiry unchanged");

        // R7 field rewrite, R4 enable sticky
        wr(4'h0, {8'd2, 8'h1C}, ew);
        wr(4'h0, {8'd6, 8'h18}, e2);
        rd(4'h0, v); chk("R4 enable stays", v, 16'h061C);
        expect_rst(expiry_edge(ew, 2), "R7 old count kept");
        wr(4'h0, {8'd1, 8'h1C}, ew);
        wr(4'h0, {8'd4, 8'h1C}, e2);
        wr(4'h2, 16'h5555, e2);
        wr(4'h2, 16'hAAAA, er);
        expect_rst(expiry_edge(er, 4), "R7 new field on reload");

        // R3 random service patterns
        for (int it = 0; it < 10; it++) begin
            int n, pat, dly, rl, ex;
            n   = 1 + $urandom_range(5);
            pat = $urandom_range(3);
            wr(4'h0, {n[7:0], 8'h1C}, ew);
            dly = $urandom_range((n + 1) * T - 8, 1);
            repeat (dly) @(negedge clk);
            rl = -1;
            case (pat)
                0: begin wr(4'h2, 16'h5555, e2); wr(4'h2, 16'hAAAA, rl); end
                1: begin wr(4'h2, 16'hAAAA, e2); wr(4'h2, 16'h5555, e2); end
                2: begin wr(4'h2, 16'h5555, e2); wr(4'h2, 16'h1234, e2);
                         wr(4'h2, 16'hAAAA, e2); end
                default: begin wr(4'h2, 16'h5555, e2); wr(4'h2, 16'h5555, e2);
                               wr(4'h2, 16'hAAAA, rl); end
            endcase
            ex = (rl >= 0) ? expiry_edge(rl, n) : expiry_edge(ew, n);
            expect_rst(ex, "R3 service pattern");
        end

        // R5 write-once hold, R6 freeze
        begin
            int len;
            len = 5 + $urandom_range(6);
            wr(4'h0, {8'd3, 8'h1D}, ew);
            wr(4'h0, {8'd3, 8'h1C}, e2);
            rd(4'h0, v); chk("R5 hold kept set", v, 16'h031D);
            lp_window(len);
            expect_rst(expiry_edge(ew, 3) + len, "R6 frozen window");
            wr(4'h0, {8'd3, 8'h1C}, ew);
            wr(4'h0, {8'd3, 8'h1D}, e2);
            rd(4'h0, v); chk("R5 hold kept clear", v, 16'h031C);
            lp_window(len);
            expect_rst(expiry_edge(ew, 3), "R6 no hold no freeze");
        end

        // R9 silent wrap
        begin
            int seen;
            seen = 0;
            wr(4'h0, {8'd2, 8'h14}, ew);
            while (ecnt < ew + 2 * 3 * T + 2) begin
                @(negedge clk);
                if (wdog_rst_o) seen = seen + 1;
            end
            chk("R9 no reset request", seen, 0);
            rd(4'h0, v); chk("R9 still enabled", v, 16'h0214);
            wr(4'h0, {8'd2, 8'h1C}, e2);
            expect_rst(ew + 3 * 3 * T, "R9 wrap period");
        end

        // R11 power-down pulse from first phase
        while (ecnt < rel + PDN + 4) @(negedge clk);
        chk("R11 single pulse", pdn_hits, 1);
        chk("R11 pulse edge", pdn_at, rel + PDN);

        // R12 disable power-down counter
        do_reset(rel);
        wr(4'h8, 16'h0000, e2);
        wr(4'h8, 16'h0001, e2);
        rd(4'h8, v); chk("R12 stays disabled", v, 16'h0000);
        while (ecnt < rel + PDN + 10) @(negedge clk);
        chk("R12 no pulse", pdn_hits, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule